// File: doc/BRIEF.md
# Table Call and Return Unit

This block performs the control transfers of a table-indexed subroutine call and its matching return for a 32-bit processor core. A call takes a 6-bit immediate and scales it by two. It adds the result to a halfword-aligned table base and reads a 16-bit entry at that address through a valid/ready memory port. It then forms the next instruction address from the aligned base and the aligned entry. When the call starts, the unit saves the return address and the current status word. The return instruction restores the status word through a write mask and jumps to the saved address with bit 0 forced to zero.

The unit holds a small bank of system registers. The bank includes the status word, the two call-save registers and the table base. The unit also executes moves in both directions between that bank and the general register file. Instruction decode and the general register file sit outside the unit. Decode presents each operation on the `op_*` inputs. A store to a general register leaves through a one-cycle write port. Only one operation is in flight at a time. Each finished operation raises `done` for exactly one cycle.

Top module: `tbl_call_unit`

## Requirements
- R1: After reset, `done`, `next_pc_valid`, `mem_req_valid` and `gpr_we` are 0, `status_word` is 0, `op_ready` is 1, and every system register reads back 0.
- R2: A call (`op_code` 2'b00) stores `op_pc + 2` into system register 16 and the status word of that moment into system register 17.
- R3: A call issues a memory read at address (table base with bit 0 cleared) + (`op_imm` << 1), where the table base is system register 20. Arithmetic wraps modulo 2^32.
- R4: One cycle after the clock edge that samples `mem_rsp_valid` high during a call, `done` and `next_pc_valid` are 1 for one cycle. `next_pc` then equals (aligned table base) + (16-bit entry zero-extended with bit 0 cleared).
- R5: A return (`op_code` 2'b01) gives, one cycle after acceptance, `next_pc` = system register 16 with bit 0 cleared, with `next_pc_valid` and `done`. It also loads the status word with system register 17 ANDed with `STATUS_MASK` (default 32'h0000_00FF).
- R6: A load to a system register (`op_code` 2'b10) writes `op_gdata` into register `op_sidx`. When the index is 5 (the status word), the value is ANDed with `STATUS_MASK` first. `status_word` never has bits set outside the mask.
- R7: A store from a system register (`op_code` 2'b11) pulses `gpr_we` with `done`, one cycle after acceptance. It presents `gpr_waddr` = `op_gidx` and `gpr_wdata` = the unmodified contents of register `op_sidx`.
- R8: `done` never stays high two cycles in a row. `op_ready` is 0 from call acceptance until the cycle after its `done`. An operation offered while `op_ready` is 0 has no effect.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged. The unit waits for the response only after the request handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered by decode |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 2 | 00 call, 01 return, 10 load system reg, 11 store system reg |
| op_pc | input | 32 | Address of the current instruction |
| op_imm | input | 6 | Table index for a call |
| op_sidx | input | 5 | System register index |
| op_gidx | input | 5 | Destination general register for a store |
| op_gdata | input | 32 | Source general register value for a load |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 16 | Table entry |
| gpr_we | output | 1 | General register write strobe |
| gpr_waddr | output | 5 | General register write index |
| gpr_wdata | output | 32 | General register write value |
| next_pc_valid | output | 1 | Next PC is valid |
| next_pc | output | 32 | Target of the call or return |
| done | output | 1 | One-cycle completion pulse |
| status_word | output | 32 | Current status word |

## Verification
The properties assume that memory returns a response only after it accepts a request. They also assume that decode holds an offered operation only while it watches `op_ready`. The bench drives every input at the falling edge. It raises `mem_rsp_valid` only once the unit has entered its wait-for-data phase. It offers one operation deliberately while the unit is busy, and holds that operation for just one edge. Table bases, immediates and entries at the top of their ranges exercise address wrap without any out-of-protocol input.

// File: rtl/tbl_call_pkg.sv
package tbl_call_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'b00,
    OP_RET  = 2'b01,
    OP_LDSR = 2'b10,
    OP_STSR = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } st_e;

endpackage

// File: rtl/tbl_call_sregs.sv
module tbl_call_sregs #(
  parameter int XLEN        = 32,
  parameter int NREG        = 32,
  parameter int IW          = 5,
  parameter int IDX_STATUS  = 5,
  parameter int IDX_SAVE_PC = 16,
  parameter int IDX_SAVE_ST = 17,
  parameter int IDX_TBASE   = 20,
  parameter logic [XLEN-1:0] STATUS_MASK = 32'h0000_00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_en,
  input  logic [XLEN-1:0] save_pc,
  input  logic            st_load_en,
  input  logic [XLEN-1:0] st_load_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] status,
  output logic [XLEN-1:0] tbase,
  output logic [XLEN-1:0] save_pc_q,
  output logic [XLEN-1:0] save_st_q
);

  logic [NREG-1:0][XLEN-1:0] bank;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] d;
    logic            en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (wr_en && (wr_idx == IW'(g))) begin
        en = 1'b1;
        if (g == IDX_STATUS) d = wr_data & STATUS_MASK;
        else                 d = wr_data;
      end
      if (g == IDX_SAVE_PC && save_en) begin
        en = 1'b1;
        d  = save_pc;
      end
      if (g == IDX_SAVE_ST && save_en) begin
        en = 1'b1;
        d  = bank[IDX_STATUS];
      end
      if (g == IDX_STATUS && st_load_en) begin
        en = 1'b1;
        d  = st_load_data & STATUS_MASK;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign bank[g] = q;
  end

  assign rd_data   = bank[rd_idx];
  assign status    = bank[IDX_STATUS];
  assign tbase     = bank[IDX_TBASE];
  assign save_pc_q = bank[IDX_SAVE_PC];
  assign save_st_q = bank[IDX_SAVE_ST];

endmodule

// File: rtl/tbl_call_tgt.sv
module tbl_call_tgt #(
  parameter int XLEN = 32,
  parameter int IMMW = 6,
  parameter int EW   = 16
) (
  input  logic [XLEN-1:0] tbase,
  input  logic [IMMW-1:0] imm,
  input  logic [XLEN-1:0] base_held,
  input  logic [EW-1:0]   entry,
  output logic [XLEN-1:0] base_al,
  output logic [XLEN-1:0] entry_addr,
  output logic [XLEN-1:0] target
);

  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  logic [XLEN-1:0] scaled_idx;
  logic [XLEN-1:0] entry_al;

  assign base_al    = tbase & LSB_CLR;
  assign scaled_idx = {{(XLEN-IMMW-1){1'b0}}, imm, 1'b0};
  assign entry_addr = base_al + scaled_idx;
  assign entry_al   = {{(XLEN-EW){1'b0}}, entry} & LSB_CLR;
  assign target     = base_held + entry_al;

endmodule

// File: rtl/tbl_call_ctl.sv
module tbl_call_ctl
  import tbl_call_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 6,
  parameter int EW   = 16,
  parameter int IW   = 5,
  parameter int GW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [1:0]      op_code,
  input  logic [XLEN-1:0] op_pc,
  input  logic [IMMW-1:0] op_imm,
  input  logic [IW-1:0]   op_sidx,
  input  logic [GW-1:0]   op_gidx,
  input  logic [XLEN-1:0] op_gdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [EW-1:0]   mem_rsp_data,
  output logic            gpr_we,
  output logic [GW-1:0]   gpr_waddr,
  output logic [XLEN-1:0] gpr_wdata,
  output logic            next_pc_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            done,
  output logic            sr_wr_en,
  output logic [IW-1:0]   sr_wr_idx,
  output logic [XLEN-1:0] sr_wr_data,
  output logic            sr_save_en,
  output logic [XLEN-1:0] sr_save_pc,
  output logic            sr_st_load_en,
  output logic [XLEN-1:0] sr_st_load_data,
  output logic [IW-1:0]   sr_rd_idx,
  input  logic [XLEN-1:0] sr_rd_data,
  input  logic [XLEN-1:0] sr_tbase,
  input  logic [XLEN-1:0] sr_save_pc_q,
  input  logic [XLEN-1:0] sr_save_st_q
);

  localparam logic [XLEN-1:0] LSB_CLR  = ~XLEN'(1);
  localparam logic [XLEN-1:0] PC_STEP  = XLEN'(2);

  st_e             state_q, state_d;
  logic            done_q, done_d;
  logic            npcv_q, npcv_d;
  logic            gwe_q, gwe_d;
  logic [XLEN-1:0] npc_q, npc_d;
  logic [GW-1:0]   gaddr_q, gaddr_d;
  logic [XLEN-1:0] gdata_q, gdata_d;
  logic [XLEN-1:0] addr_q, base_q;
  logic            ld_req, ld_npc, ld_gpr;
  logic            accept;
  op_e             op;

  logic [XLEN-1:0] base_al, entry_addr, target;

  tbl_call_tgt #(.XLEN(XLEN), .IMMW(IMMW), .EW(EW)) u_tgt (
    .tbase      (sr_tbase),
    .imm        (op_imm),
    .base_held  (base_q),
    .entry      (mem_rsp_data),
    .base_al    (base_al),
    .entry_addr (entry_addr),
    .target     (target)
  );

  assign op       = op_e'(op_code);
  assign op_ready = (state_q == ST_IDLE) && !done_q;
  assign accept   = op_valid && op_ready;

  // System register bank controls, all taken at the accepting edge
  assign sr_wr_en        = accept && (op == OP_LDSR);
  assign sr_wr_idx       = op_sidx;
  assign sr_wr_data      = op_gdata;
  assign sr_save_en      = accept && (op == OP_CALL);
  assign sr_save_pc      = op_pc + PC_STEP;
  assign sr_st_load_en   = accept && (op == OP_RET);
  assign sr_st_load_data = sr_save_st_q;
  assign sr_rd_idx       = op_sidx;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    npcv_d  = 1'b0;
    gwe_d   = 1'b0;
    npc_d   = npc_q;
    gaddr_d = gaddr_q;
    gdata_d = gdata_q;
    ld_req  = 1'b0;
    ld_npc  = 1'b0;
    ld_gpr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_CALL: begin
              state_d = ST_REQ;
              ld_req  = 1'b1;
            end
            OP_RET: begin
              done_d = 1'b1;
              npcv_d = 1'b1;
              ld_npc = 1'b1;
              npc_d  = sr_save_pc_q & LSB_CLR;
            end
            OP_LDSR: begin
              done_d = 1'b1;
            end
            OP_STSR: begin
              done_d  = 1'b1;
              gwe_d   = 1'b1;
              ld_gpr  = 1'b1;
              gaddr_d = op_gidx;
              gdata_d = sr_rd_data;
            end
            default: ;
          endcase
        end
      end
      ST_REQ: begin
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          npcv_d  = 1'b1;
          ld_npc  = 1'b1;
          npc_d   = target;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      npcv_q  <= 1'b0;
      gwe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      npcv_q  <= npcv_d;
      gwe_q   <= gwe_d;
    end
  end

  // Data registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      base_q  <= '0;
      npc_q   <= '0;
      gaddr_q <= '0;
      gdata_q <= '0;
    end else begin
      if (ld_req) begin
        addr_q <= entry_addr;
        base_q <= base_al;
      end
      if (ld_npc) npc_q <= npc_d;
      if (ld_gpr) begin
        gaddr_q <= gaddr_d;
        gdata_q <= gdata_d;
      end
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign gpr_we        = gwe_q;
  assign gpr_waddr     = gaddr_q;
  assign gpr_wdata     = gdata_q;
  assign next_pc_valid = npcv_q;
  assign next_pc       = npc_q;
  assign done          = done_q;

endmodule

// File: rtl/tbl_call_unit.sv
module tbl_call_unit #(
  parameter int XLEN        = 32,
  parameter int IMMW        = 6,
  parameter int EW          = 16,
  parameter int NREG        = 32,
  parameter int GW          = 5,
  parameter int IDX_STATUS  = 5,
  parameter int IDX_SAVE_PC = 16,
  parameter int IDX_SAVE_ST = 17,
  parameter int IDX_TBASE   = 20,
  parameter logic [XLEN-1:0] STATUS_MASK = 32'h0000_00FF,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [1:0]      op_code,
  input  logic [XLEN-1:0] op_pc,
  input  logic [IMMW-1:0] op_imm,
  input  logic [IW-1:0]   op_sidx,
  input  logic [GW-1:0]   op_gidx,
  input  logic [XLEN-1:0] op_gdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [EW-1:0]   mem_rsp_data,
  output logic            gpr_we,
  output logic [GW-1:0]   gpr_waddr,
  output logic [XLEN-1:0] gpr_wdata,
  output logic            next_pc_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            done,
  output logic [XLEN-1:0] status_word
);

  logic            sr_wr_en, sr_save_en, sr_st_load_en;
  logic [IW-1:0]   sr_wr_idx, sr_rd_idx;
  logic [XLEN-1:0] sr_wr_data, sr_save_pc, sr_st_load_data, sr_rd_data;
  logic [XLEN-1:0] sr_tbase, sr_save_pc_q, sr_save_st_q;

  tbl_call_sregs #(
    .XLEN(XLEN), .NREG(NREG), .IW(IW),
    .IDX_STATUS(IDX_STATUS), .IDX_SAVE_PC(IDX_SAVE_PC),
    .IDX_SAVE_ST(IDX_SAVE_ST), .IDX_TBASE(IDX_TBASE),
    .STATUS_MASK(STATUS_MASK)
  ) u_sregs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (sr_wr_en),
    .wr_idx       (sr_wr_idx),
    .wr_data      (sr_wr_data),
    .save_en      (sr_save_en),
    .save_pc      (sr_save_pc),
    .st_load_en   (sr_st_load_en),
    .st_load_data (sr_st_load_data),
    .rd_idx       (sr_rd_idx),
    .rd_data      (sr_rd_data),
    .status       (status_word),
    .tbase        (sr_tbase),
    .save_pc_q    (sr_save_pc_q),
    .save_st_q    (sr_save_st_q)
  );

  tbl_call_ctl #(
    .XLEN(XLEN), .IMMW(IMMW), .EW(EW), .IW(IW), .GW(GW)
  ) u_ctl (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_valid        (op_valid),
    .op_ready        (op_ready),
    .op_code         (op_code),
    .op_pc           (op_pc),
    .op_imm          (op_imm),
    .op_sidx         (op_sidx),
    .op_gidx         (op_gidx),
    .op_gdata        (op_gdata),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_data    (mem_rsp_data),
    .gpr_we          (gpr_we),
    .gpr_waddr       (gpr_waddr),
    .gpr_wdata       (gpr_wdata),
    .next_pc_valid   (next_pc_valid),
    .next_pc         (next_pc),
    .done            (done),
    .sr_wr_en        (sr_wr_en),
    .sr_wr_idx       (sr_wr_idx),
    .sr_wr_data      (sr_wr_data),
    .sr_save_en      (sr_save_en),
    .sr_save_pc      (sr_save_pc),
    .sr_st_load_en   (sr_st_load_en),
    .sr_st_load_data (sr_st_load_data),
    .sr_rd_idx       (sr_rd_idx),
    .sr_rd_data      (sr_rd_data),
    .sr_tbase        (sr_tbase),
    .sr_save_pc_q    (sr_save_pc_q),
    .sr_save_st_q    (sr_save_st_q)
  );

endmodule

// File: rtl/tbl_call_unit_chk.sv
module tbl_call_unit_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] STATUS_MASK = 32'h0000_00FF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            next_pc_valid,
  input logic [XLEN-1:0] next_pc,
  input logic            done,
  input logic            gpr_we,
  input logic [XLEN-1:0] status_word
);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !op_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_npc_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_valid |-> done);

  p_npc_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_valid |-> !next_pc[0]);

  p_gpr_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> (done && !next_pc_valid));

  p_status_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~STATUS_MASK) == '0);

endmodule

bind tbl_call_unit tbl_call_unit_chk #(.XLEN(XLEN), .STATUS_MASK(STATUS_MASK)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_ready      (op_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .next_pc_valid (next_pc_valid),
  .next_pc       (next_pc),
  .done          (done),
  .gpr_we        (gpr_we),
  .status_word   (status_word)
);

// File: tb/tbl_call_unit_bench.sv
module tbl_call_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_code;
  logic [31:0] op_pc;
  logic [5:0]  op_imm;
  logic [4:0]  op_sidx;
  logic [4:0]  op_gidx;
  logic [31:0] op_gdata;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        gpr_we;
  logic [4:0]  gpr_waddr;
  logic [31:0] gpr_wdata;
  logic        next_pc_valid;
  logic [31:0] next_pc;
  logic        done;
  logic [31:0] status_word;

  int checks = 0;
  int errors = 0;

  tbl_call_unit u_tbl_call_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_pc(op_pc), .op_imm(op_imm), .op_sidx(op_sidx),
    .op_gidx(op_gidx), .op_gdata(op_gdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .next_pc_valid(next_pc_valid), .next_pc(next_pc), .done(done),
    .status_word(status_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {sreg index, value written, value read back}
  localparam logic [68:0] VEC [0:5] = '{
    {5'd5,  32'hABCD_125A, 32'h0000_005A},
    {5'd16, 32'h1234_5679, 32'h1234_5679},
    {5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {5'd3,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'd31, 32'h8000_0001, 32'h8000_0001},
    {5'd20, 32'h0000_1001, 32'h0000_1001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operation; returns at the falling edge after the accepting edge
  task automatic do_op(input logic [1:0] code, input logic [31:0] pc, input logic [5:0] imm,
                       input logic [4:0] sidx, input logic [4:0] gidx, input logic [31:0] gdata);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_pc = pc; op_imm = imm;
    op_sidx = sidx; op_gidx = gidx; op_gdata = gdata;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic read_sreg(input logic [4:0] idx, input logic [4:0] gidx,
                           input string req, input logic [31:0] exp);
    do_op(2'b11, 32'h0, 6'h0, idx, gidx, 32'h0);
    check(req, {31'h0, gpr_we}, 32'h1);
    check(req, {27'h0, gpr_waddr}, {27'h0, gidx});
    check(req, gpr_wdata, exp);
  endtask

  // Runs a call with the table memory; wait_cycles of ready held low
  task automatic run_call(input logic [31:0] pc, input logic [5:0] imm, input logic [31:0] exp_addr,
                          input logic [15:0] entry, input logic [31:0] exp_npc, input int wait_cycles);
    do_op(2'b00, pc, imm, 5'd0, 5'd0, 32'h0);
    check("R3 req valid", {31'h0, mem_req_valid}, 32'h1);
    check("R3 req addr", mem_req_addr, exp_addr);
    check("R8 busy ready", {31'h0, op_ready}, 32'h0);
    for (int k = 0; k < wait_cycles; k++) begin
      op_valid = 1'b1; op_code = 2'b11; op_sidx = 5'd3; op_gidx = 5'd9;
      @(negedge clk);
      op_valid = 1'b0;
      check("R9 req held", {31'h0, mem_req_valid}, 32'h1);
      check("R9 addr held", mem_req_addr, exp_addr);
      check("R8 ignored op", {31'h0, gpr_we}, 32'h0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check("R9 req dropped", {31'h0, mem_req_valid}, 32'h0);
    check("R4 no early done", {31'h0, done}, 32'h0);
    mem_rsp_valid = 1'b1; mem_rsp_data = entry;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check("R4 done", {31'h0, done}, 32'h1);
    check("R4 npc valid", {31'h0, next_pc_valid}, 32'h1);
    check("R4 npc", next_pc, exp_npc);
    @(negedge clk);
    check("R8 single done", {31'h0, done}, 32'h0);
    check("R8 ready back", {31'h0, op_ready}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'b00; op_pc = '0; op_imm = '0;
    op_sidx = '0; op_gidx = '0; op_gdata = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 npc valid", {31'h0, next_pc_valid}, 32'h0);
    check("R1 req", {31'h0, mem_req_valid}, 32'h0);
    check("R1 gpr_we", {31'h0, gpr_we}, 32'h0);
    check("R1 status", status_word, 32'h0);
    check("R1 ready", {31'h0, op_ready}, 32'h1);
    rst_n = 1'b1;
    read_sreg(5'd20, 5'd1, "R1 tbase zero", 32'h0);

    // R6 / R7 vector walk: load then store back
    for (int i = 0; i < 6; i++) begin
      do_op(2'b10, 32'h0, 6'h0, VEC[i][68:64], 5'd0, VEC[i][63:32]);
      check("R6 ld done", {31'h0, done}, 32'h1);
      check("R6 ld no gpr", {31'h0, gpr_we}, 32'h0);
      read_sreg(VEC[i][68:64], 5'(i + 2), "R7 readback", VEC[i][31:0]);
    end
    check("R6 status port", status_word, 32'h0000_005A);

    // R2 R3 R4 R9 call: base 0x1001 -> 0x1000, imm 42 -> 0x1054, entry 0x0123
    run_call(32'h0000_4000, 6'd42, 32'h0000_1054, 16'h0123, 32'h0000_1122, 3);
    read_sreg(5'd16, 5'd4, "R2 saved pc", 32'h0000_4002);
    read_sreg(5'd17, 5'd5, "R2 saved status", 32'h0000_005A);

    // R5 return restores masked status
    do_op(2'b10, 32'h0, 6'h0, 5'd5, 5'd0, 32'h0000_003C);
    check("R6 status new", status_word, 32'h0000_003C);
    do_op(2'b01, 32'h0000_1122, 6'h0, 5'd0, 5'd0, 32'h0);
    check("R5 done", {31'h0, done}, 32'h1);
    check("R5 npc valid", {31'h0, next_pc_valid}, 32'h1);
    check("R5 npc", next_pc, 32'h0000_4002);
    check("R5 status", status_word, 32'h0000_005A);

    // R5 alignment and mask on return
    do_op(2'b10, 32'h0, 6'h0, 5'd16, 5'd0, 32'h0000_7777);
    do_op(2'b10, 32'h0, 6'h0, 5'd17, 5'd0, 32'hFFFF_FF81);
    do_op(2'b01, 32'h0, 6'h0, 5'd0, 5'd0, 32'h0);
    check("R5 npc aligned", next_pc, 32'h0000_7776);
    check("R5 status masked", status_word, 32'h0000_0081);

    // R3 R4 wrap corner: base 0xFFFFFFF1, imm 63, entry 0xFFFF, ready at once
    do_op(2'b10, 32'h0, 6'h0, 5'd20, 5'd0, 32'hFFFF_FFF1);
    run_call(32'h8000_0000, 6'd63, 32'h0000_006E, 16'hFFFF, 32'h0000_FFEE, 0);
    read_sreg(5'd16, 5'd6, "R2 saved pc 2", 32'h8000_0002);
    read_sreg(5'd17, 5'd7, "R2 saved status 2", 32'h0000_0081);

    // R1 reset mid-run clears the bank
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 status after reset", status_word, 32'h0);
    rst_n = 1'b1;
    read_sreg(5'd16, 5'd8, "R1 saved pc cleared", 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule